// File: doc/BRIEF.md
# Windowed Register File with Automatic Spill and Fill

This block is a register file whose upper address range is seen through a sliding window. A fixed set of global registers is visible from every window. Each window also exposes an input section, a local section and an output section, and the output section of one window is the same storage as the input section of the next window. A caller places arguments in its output registers, and after a call the callee finds them in its input registers without any copying.

The physical store holds `NUM_GLOB + 2*WIN_REGS*NUM_WIN` words. A call moves the current window forward by one and a return moves it back by one. The block keeps its own count of how many more calls and how many more returns it can serve from resident storage. When a call finds no free window, the block first streams the oldest resident window out to memory. When a return finds its caller's window absent, the block first streams that window back in from memory. During either transfer the block is busy and holds off ordinary accesses. The memory is outside the block and behaves as a stack.

Writes and reads are synchronous. A read and a write may both be issued in the same cycle, including to the same register.

Top module: `winreg_file`

## Requirements
- R1: A reset is taken when `rst_n` is low at a rising edge. It clears every register and both read outputs to zero, drops `busy_o`, `spill_o` and `fill_o`, selects window 0, and allows `NUM_WIN-2` calls before the first spill.
- R2: Virtual addresses below `NUM_GLOB` name the same global register from every window.
- R3: A write lands at the rising edge when `en_i`, `we_i` are high and `busy_o` is low. A read is registered at the rising edge when `en_i` and its read enable are high and `busy_o` is low. A read of the register written at the same edge returns the value it held before that write.
- R4: The two read ports use independent addresses and enables. A port whose enable is low keeps its output.
- R5: Virtual addresses `NUM_GLOB..NUM_GLOB+WIN_REGS-1` are the input section, the next `WIN_REGS` are the local section, and the next `WIN_REGS` are the output section. After a call, the callee's input register k holds the caller's output register k. The callee's locals are storage distinct from the caller's locals.
- R6: A call or return that can be served from resident windows completes at its edge without raising `busy_o`. A return restores the caller's locals. The number of remaining calls plus the number of remaining returns always equals `NUM_WIN-2`.
- R7: A call with no call budget left raises `spill_o` and `busy_o` for exactly `2*WIN_REGS` cycles. In those cycles `mem_wdata_o` carries the oldest resident window, input registers 0..N-1 first and then locals 0..N-1. After that the window advances.
- R8: A return with no return budget left raises `fill_o` and `busy_o` for exactly `2*WIN_REGS` cycles. The word on `mem_rdata_i` at the closing edge of each of those cycles is written in the reverse of spill order, local N-1 first and input 0 last. After that the window moves back.
- R9: While `busy_o` is high, `call_i`, `ret_i`, writes and reads are ignored, and both read outputs hold their values.
- R10: While `en_i` is low, no register, read output or window position changes.
- R11: When `call_i` and `ret_i` are high in the same cycle, the call is taken and the return is ignored.
- R12: A chain of calls deeper than `NUM_WIN` followed by the matching returns gives back every global, input, local and output value written at each depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Block enable, active high |
| call_i | input | 1 | Open a new window |
| ret_i | input | 1 | Return to the previous window |
| we_i | input | 1 | Write enable |
| waddr_i | input | VA_W | Virtual write address |
| wdata_i | input | DATA_W | Write data |
| re1_i | input | 1 | Read port 1 enable |
| raddr1_i | input | VA_W | Read port 1 virtual address |
| rdata1_o | output | DATA_W | Read port 1 data (registered) |
| re2_i | input | 1 | Read port 2 enable |
| raddr2_i | input | VA_W | Read port 2 virtual address |
| rdata2_o | output | DATA_W | Read port 2 data (registered) |
| busy_o | output | 1 | A spill or fill is running |
| spill_o | output | 1 | `mem_wdata_o` carries a word to store |
| fill_o | output | 1 | `mem_rdata_i` is taken at the coming edge |
| mem_wdata_o | output | DATA_W | Word streamed out to memory |
| mem_rdata_i | input | DATA_W | Word streamed in from memory |

## Verification
Two kinds of collision can fall in one cycle. The first is a read and a write to the same register, provoked by raising both enables on one address in one cycle; the read output must show the old value and a following read the new one. The second is a window move together with ordinary accesses: requests held high through a spill must leave no trace, and a call issued with a return in the same cycle must behave as a call, which is judged by reading the callee's input register against the caller's output register. A call chain of seven levels over four windows forces five spills and five fills. The words streamed out and every register read back after unwinding are compared with values computed from depth and address.

// File: rtl/winreg_pkg.sv
// Package: shared types for the windowed register file.
// Assumes: nothing beyond the SystemVerilog type system.
package winreg_pkg;
    // Sequencer phases: idle, streaming a window out, streaming one in.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SPILL = 2'd1,
        SEQ_FILL  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/winreg_xlate.sv
// Module: winreg_xlate
// Maps one virtual register address onto its physical slot.
// Globals map one to one. Windowed addresses are offset by cwp*2N and
// wrap modulo the windowed area.
// Assumes NUM_WIN >= 2, so one conditional subtraction brings the
// offset back into range.
module winreg_xlate #(
    parameter int NUM_GLOB = 4,
    parameter int WIN_REGS = 4,
    parameter int NUM_WIN  = 4,
    parameter int VA_W     = 4,
    parameter int PA_W     = 6,
    parameter int WP_W     = 2
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  logic [WP_W-1:0] cwp_i,
    output logic [PA_W-1:0] paddr_o
);
    localparam int BLK  = 2 * WIN_REGS;
    localparam int AREA = BLK * NUM_WIN;
    localparam int OW   = PA_W + 1;

    logic [OW-1:0] off;

    // Purpose: global pass-through or wrapped window offset.
    always_comb begin
        off = '0;
        if (vaddr_i < VA_W'(NUM_GLOB)) begin
            paddr_o = PA_W'(vaddr_i);
        end else begin
            off = OW'(cwp_i) * OW'(BLK) + OW'(vaddr_i) - OW'(NUM_GLOB);
            if (off >= OW'(AREA)) off = off - OW'(AREA);
            paddr_o = PA_W'(off + OW'(NUM_GLOB));
        end
    end
endmodule

// File: rtl/winreg_ctrl.sv
// Module: winreg_ctrl
// Owns the window pointers and the call/return budgets, and sequences
// spill and fill transfers one word per enabled cycle.
// Assumes the caller ignores requests while busy_o is high. Returns past
// the base window are not guarded.
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NUM_GLOB = 4,
    parameter int WIN_REGS = 4,
    parameter int NUM_WIN  = 4,
    parameter int PA_W     = 6,
    parameter int WP_W     = 2,
    parameter int CS_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            call_i,
    input  logic            ret_i,
    output logic [WP_W-1:0] cwp_o,
    output logic [CS_W-1:0] cansave_o,
    output logic [CS_W-1:0] canrestore_o,
    output logic            busy_o,
    output logic            spill_o,
    output logic            fill_o,
    output logic [PA_W-1:0] seq_paddr_o
);
    localparam int BLK   = 2 * WIN_REGS;
    localparam int CNT_W = (BLK > 2) ? $clog2(BLK) : 1;
    localparam int OW    = PA_W + 1;

    seq_state_e      state;
    logic [WP_W-1:0] cwp, swp, cwp_up, cwp_dn, swp_up, swp_dn, blk;
    logic [CS_W-1:0] cansave, canrestore;
    logic [CNT_W-1:0] cnt;

    // Purpose: wrapped neighbours of both window pointers.
    always_comb begin
        cwp_up = (cwp == WP_W'(NUM_WIN - 1)) ? '0 : cwp + 1'b1;
        cwp_dn = (cwp == '0) ? WP_W'(NUM_WIN - 1) : cwp - 1'b1;
        swp_up = (swp == WP_W'(NUM_WIN - 1)) ? '0 : swp + 1'b1;
        swp_dn = (swp == '0) ? WP_W'(NUM_WIN - 1) : swp - 1'b1;
    end

    // Purpose: pointer, budget and transfer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            cwp        <= '0;
            swp        <= '0;
            cansave    <= CS_W'(NUM_WIN - 2);
            canrestore <= '0;
            cnt        <= '0;
        end else if (en_i) begin
            case (state)
                SEQ_IDLE: begin
                    if (call_i) begin
                        if (cansave != '0) begin
                            cwp        <= cwp_up;
                            cansave    <= cansave - 1'b1;
                            canrestore <= canrestore + 1'b1;
                        end else begin
                            state <= SEQ_SPILL;
                            cnt   <= '0;
                        end
                    end else if (ret_i) begin
                        if (canrestore != '0) begin
                            cwp        <= cwp_dn;
                            canrestore <= canrestore - 1'b1;
                            cansave    <= cansave + 1'b1;
                        end else begin
                            state <= SEQ_FILL;
                            cnt   <= CNT_W'(BLK - 1);
                        end
                    end
                end
                SEQ_SPILL: begin
                    if (cnt == CNT_W'(BLK - 1)) begin
                        state <= SEQ_IDLE;
                        swp   <= swp_up;
                        cwp   <= cwp_up;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_FILL: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                        swp   <= swp_dn;
                        cwp   <= cwp_dn;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: physical slot of the word currently being moved.
    always_comb begin
        blk         = (state == SEQ_FILL) ? swp_dn : swp;
        seq_paddr_o = PA_W'(OW'(NUM_GLOB) + OW'(blk) * OW'(BLK) + OW'(cnt));
    end

    assign cwp_o        = cwp;
    assign cansave_o    = cansave;
    assign canrestore_o = canrestore;
    assign busy_o       = (state != SEQ_IDLE);
    assign spill_o      = (state == SEQ_SPILL);
    assign fill_o       = (state == SEQ_FILL);
endmodule

// File: rtl/winreg_store.sv
// Module: winreg_store
// Physical storage: one write port, two registered read ports and one
// combinational tap for outbound transfers.
// Assumes the addresses are in range. Reads see pre-write contents.
module winreg_store #(
    parameter int DATA_W = 64,
    parameter int PHYS_N = 36,
    parameter int PA_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PA_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd1_en_i,
    input  logic [PA_W-1:0]   rd1_addr_i,
    output logic [DATA_W-1:0] rd1_data_o,
    input  logic              rd2_en_i,
    input  logic [PA_W-1:0]   rd2_addr_i,
    output logic [DATA_W-1:0] rd2_data_o,
    input  logic [PA_W-1:0]   tap_addr_i,
    output logic [DATA_W-1:0] tap_data_o
);
    logic [DATA_W-1:0] regs [PHYS_N];

    // Purpose: clear on reset, else write and register both reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) regs[i] <= '0;
            rd1_data_o <= '0;
            rd2_data_o <= '0;
        end else begin
            if (wr_en_i)  regs[wr_addr_i] <= wr_data_i;
            if (rd1_en_i) rd1_data_o <= regs[rd1_addr_i];
            if (rd2_en_i) rd2_data_o <= regs[rd2_addr_i];
        end
    end

    assign tap_data_o = regs[tap_addr_i];
endmodule

// File: rtl/winreg_file.sv
// Module: winreg_file (top)
// Windowed register file with overlapping in/out sections and automatic
// transfers to and from an external stack memory.
// Assumes the external memory is a stack: it accepts words while spill_o
// is high and supplies the last stored word while fill_o is high.
module winreg_file #(
    parameter int DATA_W   = 64,
    parameter int NUM_GLOB = 4,
    parameter int WIN_REGS = 4,
    parameter int NUM_WIN  = 4,
    localparam int VIRT_N  = NUM_GLOB + 3 * WIN_REGS,
    localparam int VA_W    = $clog2(VIRT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              we_i,
    input  logic [VA_W-1:0]   waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re1_i,
    input  logic [VA_W-1:0]   raddr1_i,
    output logic [DATA_W-1:0] rdata1_o,
    input  logic              re2_i,
    input  logic [VA_W-1:0]   raddr2_i,
    output logic [DATA_W-1:0] rdata2_o,
    output logic              busy_o,
    output logic              spill_o,
    output logic              fill_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int PHYS_N = NUM_GLOB + 2 * WIN_REGS * NUM_WIN;
    localparam int PA_W   = $clog2(PHYS_N);
    localparam int WP_W   = $clog2(NUM_WIN);
    localparam int CS_W   = $clog2(NUM_WIN);
    localparam int NPORT  = 3;

    logic [WP_W-1:0]   cwp;
    logic [CS_W-1:0]   cansave, canrestore;
    logic [PA_W-1:0]   seq_paddr, wr_addr;
    logic [VA_W-1:0]   va [NPORT];
    logic [PA_W-1:0]   pa [NPORT];
    logic [DATA_W-1:0] wr_data, tap_data;
    logic              wr_en, rd1_en, rd2_en;

    winreg_ctrl #(
        .NUM_GLOB(NUM_GLOB), .WIN_REGS(WIN_REGS), .NUM_WIN(NUM_WIN),
        .PA_W(PA_W), .WP_W(WP_W), .CS_W(CS_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .call_i(call_i), .ret_i(ret_i),
        .cwp_o(cwp), .cansave_o(cansave), .canrestore_o(canrestore),
        .busy_o(busy_o), .spill_o(spill_o), .fill_o(fill_o),
        .seq_paddr_o(seq_paddr)
    );

    assign va[0] = waddr_i;
    assign va[1] = raddr1_i;
    assign va[2] = raddr2_i;

    // One translator per access port, all steered by the same window.
    for (genvar g = 0; g < NPORT; g++) begin : g_xl
        winreg_xlate #(
            .NUM_GLOB(NUM_GLOB), .WIN_REGS(WIN_REGS), .NUM_WIN(NUM_WIN),
            .VA_W(VA_W), .PA_W(PA_W), .WP_W(WP_W)
        ) u_xl (
            .vaddr_i(va[g]), .cwp_i(cwp), .paddr_o(pa[g])
        );
    end

    // Purpose: give the write port to the fill stream while it runs.
    always_comb begin
        wr_en   = en_i & (fill_o | (we_i & ~busy_o));
        wr_addr = fill_o ? seq_paddr : pa[0];
        wr_data = fill_o ? mem_rdata_i : wdata_i;
        rd1_en  = en_i & re1_i & ~busy_o;
        rd2_en  = en_i & re2_i & ~busy_o;
    end

    winreg_store #(
        .DATA_W(DATA_W), .PHYS_N(PHYS_N), .PA_W(PA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd1_en_i(rd1_en), .rd1_addr_i(pa[1]), .rd1_data_o(rdata1_o),
        .rd2_en_i(rd2_en), .rd2_addr_i(pa[2]), .rd2_data_o(rdata2_o),
        .tap_addr_i(seq_paddr), .tap_data_o(tap_data)
    );

    assign mem_wdata_o = spill_o ? tap_data : '0;
endmodule

// File: rtl/winreg_file_chk.sv
// Module: winreg_file_chk
// Temporal checks on the windowed register file, bound into every
// instance of the top module.
// Assumes the synchronous active-low reset of the top.
module winreg_file_chk #(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 64,
    parameter int WP_W    = 2,
    parameter int CS_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              busy_o,
    input logic              spill_o,
    input logic              fill_o,
    input logic [DATA_W-1:0] rdata1_o,
    input logic [DATA_W-1:0] rdata2_o,
    input logic [WP_W-1:0]   cwp,
    input logic [CS_W-1:0]   cansave,
    input logic [CS_W-1:0]   canrestore
);
    // A spill only starts from an enabled call with no budget left.
    assert_spill_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spill_o) |-> $past(en_i && call_i && cansave == '0));

    // A fill only starts from an enabled lone return with no budget left.
    assert_fill_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_o) |-> $past(en_i && ret_i && !call_i && canrestore == '0));

    // A budgeted call moves the window by one in a single edge.
    assert_fast_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && call_i && !busy_o && cansave != '0) |=>
        (!busy_o && ((32'($past(cwp)) + 1) % NUM_WIN) == 32'(cwp)));

    // The two budgets together stay constant.
    assert_budget_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cansave) + 32'(canrestore)) == (NUM_WIN - 2));

    // Read outputs hold through a busy cycle.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(rdata1_o) && $stable(rdata2_o)));

    // A disabled cycle changes neither the window nor the read outputs.
    assert_disable_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cwp) && $stable(rdata1_o) && $stable(rdata2_o)));
endmodule

bind winreg_file winreg_file_chk #(
    .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .WP_W(WP_W), .CS_W(CS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .call_i(call_i), .ret_i(ret_i),
    .busy_o(busy_o), .spill_o(spill_o), .fill_o(fill_o),
    .rdata1_o(rdata1_o), .rdata2_o(rdata2_o),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore)
);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
    localparam int M = 4, N = 4, F = 4, DW = 64, AW = 4;
    localparam int DEPTH = 7;
    localparam int VW = 76;
    // Vector: {req[3:0], op[3:0], addr[3:0], data[63:0]}
    // op 0 write, 1 read port 1 and compare, 2 read port 2 and compare, 3 call
    localparam logic [VW-1:0] VEC [12] = '{
        {4'd3, 4'd0, 4'd0,  64'h11},
        {4'd3, 4'd0, 4'd4,  64'h21},
        {4'd3, 4'd0, 4'd8,  64'h31},
        {4'd3, 4'd0, 4'd12, 64'h41},
        {4'd3, 4'd1, 4'd0,  64'h11},
        {4'd4, 4'd2, 4'd12, 64'h41},
        {4'd6, 4'd3, 4'd0,  64'h0},
        {4'd5, 4'd1, 4'd4,  64'h41},
        {4'd5, 4'd2, 4'd8,  64'h0},
        {4'd2, 4'd1, 4'd0,  64'h11},
        {4'd3, 4'd0, 4'd8,  64'h51},
        {4'd4, 4'd2, 4'd8,  64'h51}
    };

    logic clk = 0, rst_n = 0, en = 1, call = 0, ret = 0, we = 0, re1 = 0, re2 = 0;
    logic [AW-1:0] wa = '0, ra1 = '0, ra2 = '0;
    logic [DW-1:0] wd = '0, rd1, rd2, mwd, mrd = '0;
    logic busy, spill, fill;
    logic [DW-1:0] stk [64];
    int sp = 0, nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    winreg_file u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .call_i(call), .ret_i(ret),
        .we_i(we), .waddr_i(wa), .wdata_i(wd),
        .re1_i(re1), .raddr1_i(ra1), .rdata1_o(rd1),
        .re2_i(re2), .raddr2_i(ra2), .rdata2_o(rd2),
        .busy_o(busy), .spill_o(spill), .fill_o(fill),
        .mem_wdata_o(mwd), .mem_rdata_i(mrd)
    );

    // Stack memory model, driven mid-cycle.
    always @(negedge clk) begin
        if (spill && en) begin stk[sp] <= mwd; sp <= sp + 1; end
        if (fill && en)  begin mrd <= stk[sp-1]; sp <= sp - 1; end
    end

    function automatic logic [DW-1:0] fv(input int d, input int a);
        return 64'hD000_0000_0000_0000 | (64'(d) << 16) | 64'(a);
    endfunction
    function automatic logic [DW-1:0] gv(input int a);
        return 64'hC0 + 64'(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        we = 1; wa = AW'(a); wd = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rdc(input int port, input int a, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] act;
        if (port == 1) begin re1 = 1; ra1 = AW'(a); end
        else begin re2 = 1; ra2 = AW'(a); end
        @(negedge clk); re1 = 0; re2 = 0;
        act = (port == 1) ? rd1 : rd2;
        check(act === exp, req, act, exp);
    endtask

    task automatic move(input bit is_call, output int nb);
        if (is_call) call = 1; else ret = 1;
        @(negedge clk); call = 0; ret = 0;
        nb = 0;
        while (busy && nb < 100) begin nb++; @(negedge clk); end
    endtask

    task automatic do_reset();
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int nb, cs, cr, ex;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check(rd1 === '0 && rd2 === '0, "R1 read outputs", rd1, 0);
        check({busy, spill, fill} === 3'b000, "R1 status", 64'({busy, spill, fill}), 0);
        rdc(1, 9, 0, "R1 cleared register");

        // R12 / R7 / R8: deep chain over the window budget
        cs = F - 2; cr = 0;
        for (int d = 0; d <= DEPTH; d++) begin
            if (d == 0) for (int g = 0; g < M; g++) wr(g, gv(g));
            for (int k = N; k < 3 * N; k++) wr(M + k, fv(d, M + k));
            if (d < DEPTH) begin
                move(1, nb);
                ex = (cs > 0) ? 0 : 2 * N;
                check(nb == ex, (cs > 0) ? "R6 budgeted call" : "R7 spill length", 64'(nb), 64'(ex));
                if (cs > 0) begin cs--; cr++; end
                if (d == F - 2)
                    for (int k = 0; k < 2 * N; k++)
                        check(stk[k] === ((k < N) ? 64'h0 : fv(0, M + k)), "R7 spill word order",
                              stk[k], (k < N) ? 64'h0 : fv(0, M + k));
            end
        end
        for (int d = DEPTH; d >= 0; d--) begin
            for (int g = 0; g < M; g++) rdc(1 + g % 2, g, gv(g), "R2 global");
            for (int k = 0; k < N; k++)
                rdc(1 + k % 2, M + k, (d > 0) ? fv(d - 1, M + 2 * N + k) : 64'h0, "R12 input section");
            for (int k = N; k < 3 * N; k++)
                rdc(1 + k % 2, M + k, fv(d, M + k), "R12 local/output section");
            if (d > 0) begin
                move(0, nb);
                ex = (cr > 0) ? 0 : 2 * N;
                check(nb == ex, (cr > 0) ? "R6 budgeted return" : "R8 fill length", 64'(nb), 64'(ex));
                if (cr > 0) begin cr--; cs++; end
            end
        end
        check(sp == 0, "R8 stack balanced", 64'(sp), 0);

        // Table walk: R2 R3 R4 R5 R6
        do_reset();
        for (int i = 0; i < 12; i++) begin
            logic [3:0] rq, op, a;
            logic [DW-1:0] d;
            string tag;
            {rq, op, a, d} = VEC[i];
            tag = $sformatf("R%0d vector %0d", rq, i);
            case (op)
                4'd0: wr(int'(a), d);
                4'd1: rdc(1, int'(a), d, tag);
                4'd2: rdc(2, int'(a), d, tag);
                default: begin move(1, nb); check(nb == 0, tag, 64'(nb), 0); end
            endcase
        end
        // R6: return restores caller locals
        move(0, nb);
        check(nb == 0, "R6 return not busy", 64'(nb), 0);
        rdc(2, 8, 64'h31, "R6 caller local");

        // R3: read and write same register, same edge
        we = 1; wa = 4'd9; wd = 64'h77; re1 = 1; ra1 = 4'd9;
        @(negedge clk); we = 0; re1 = 0;
        check(rd1 === 64'h0, "R3 read sees old value", rd1, 0);
        rdc(1, 9, 64'h77, "R3 new value after write");

        // R10: everything frozen while disabled
        en = 0; we = 1; wa = 4'd9; wd = 64'hEE; call = 1; re1 = 1; ra1 = 4'd0;
        @(negedge clk); en = 1; we = 0; call = 0; re1 = 0;
        check(rd1 === 64'h77, "R10 read output held", rd1, 64'h77);
        rdc(2, 9, 64'h77, "R10 write blocked");
        rdc(1, 4, 64'h21, "R10 window unchanged");

        // R11: call and return together act as a call
        call = 1; ret = 1;
        @(negedge clk); call = 0; ret = 0;
        rdc(1, 4, 64'h41, "R11 call taken");
        move(0, nb);

        // R9: requests during a spill are ignored
        move(1, nb); move(1, nb);
        wr(1, 64'h99);
        rdc(1, 1, 64'h99, "R9 setup");
        call = 1;
        @(negedge clk);
        we = 1; wa = 4'd1; wd = 64'h55; re1 = 1; ra1 = 4'd2; ret = 1;
        nb = 0;
        while (busy && nb < 100) begin
            nb++;
            check(rd1 === 64'h99, "R9 read output held", rd1, 64'h99);
            @(negedge clk);
        end
        we = 0; re1 = 0; call = 0; ret = 0;
        check(nb == 2 * N, "R9 held call not restarted", 64'(nb), 64'(2 * N));
        rdc(2, 1, 64'h99, "R9 write ignored");
        summary();
    end
endmodule